// File: doc/BRIEF.md
# Pulsed Address Gate with Word Budget

This block sits on the read and write address channels of a memory-mapped bus link. It throttles the traffic on that link. A free-running window repeats an open phase of `on_len` cycles and then a closed phase of `off_len` cycles. New addresses may pass only while the window is open. During each period the block also counts the data words that complete on the read data and write data channels. Once that count reaches `word_cap`, both address channels stay closed until the next period begins.

Gating is applied by masking VALID toward the subordinate and READY toward the manager. An address that was already offered to the subordinate keeps its VALID until it is accepted, even if the window closes or the budget runs out in the meantime. The bus protocol is therefore never broken. The enables `ar_en` and `aw_en` report whether each channel currently passes.

Top module: `addr_pulse_gate`

## Requirements
- R1: After reset the period starts at the first cycle of the open phase, with a word count of zero. With a nonzero `on_len`, both enables read 1 in the first cycle after reset is released.
- R2: Counting cycles from the release of reset, cycle i is open when (i mod (on_len+off_len)) < on_len. Otherwise it is closed.
- R3: In a closed cycle, with no address held over, `arvalid_o`, `arready_o`, `awvalid_o` and `awready_o` are all 0, whatever the inputs are.
- R4: When `off_len` is 0, the window is open in every cycle.
- R5: When `on_len` is 0, both enables stay 0 in every cycle.
- R6: One word is counted for each cycle with `rvalid_i && rready_i`, and one for each cycle with `wvalid_i && wready_i`. A cycle with both counts two.
- R7: Once the word count of the current period is at least `word_cap` (with `word_cap` nonzero), both enables read 0 from the next cycle until the period ends.
- R8: The word count returns to zero when a new period begins. Beats in the final cycle of a period are not carried over, and the gates open again in the first cycle of the new period.
- R9: When `word_cap` is 0, the word count never closes the gates.
- R10: An address whose VALID was passed to the subordinate and not yet accepted keeps passing, with both VALID and READY, until the cycle in which `arready_i` (or `awready_i`) is high. This holds even while the window is closed.
- R11: Both address channels follow the same window and budget independently of each other's traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| on_len | input | 16 | Open-phase length in cycles |
| off_len | input | 16 | Closed-phase length in cycles |
| word_cap | input | 16 | Words allowed per period, 0 for no limit |
| arvalid_i | input | 1 | Read address VALID from manager |
| arready_o | output | 1 | Read address READY to manager |
| arvalid_o | output | 1 | Read address VALID to subordinate |
| arready_i | input | 1 | Read address READY from subordinate |
| awvalid_i | input | 1 | Write address VALID from manager |
| awready_o | output | 1 | Write address READY to manager |
| awvalid_o | output | 1 | Write address VALID to subordinate |
| awready_i | input | 1 | Write address READY from subordinate |
| rvalid_i | input | 1 | Read data VALID (observed) |
| rready_i | input | 1 | Read data READY (observed) |
| wvalid_i | input | 1 | Write data VALID (observed) |
| wready_i | input | 1 | Write data READY (observed) |
| ar_en | output | 1 | Read address channel currently passes |
| aw_en | output | 1 | Write address channel currently passes |

## Verification
The assertions assume that `on_len`, `off_len` and `word_cap` stay constant between resets. They also assume that a manager does not withdraw an address VALID before it is accepted. The bench changes the configuration only while reset is held, and it keeps each offered VALID raised until the cycle in which the subordinate's READY is driven high. The data channel beats are driven as plain level pairs, because the block only observes them.

// File: rtl/addr_pulse_gate.sv
module addr_pulse_gate #(
  parameter int LEN_W = 16,
  parameter int CAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] on_len,
  input  logic [LEN_W-1:0] off_len,
  input  logic [CAP_W-1:0] word_cap,
  input  logic             arvalid_i,
  output logic             arready_o,
  output logic             arvalid_o,
  input  logic             arready_i,
  input  logic             awvalid_i,
  output logic             awready_o,
  output logic             awvalid_o,
  input  logic             awready_i,
  input  logic             rvalid_i,
  input  logic             rready_i,
  input  logic             wvalid_i,
  input  logic             wready_i,
  output logic             ar_en,
  output logic             aw_en
);
  localparam int WC_W = CAP_W + 1;

  logic             on_phase;
  logic [LEN_W-1:0] cnt;
  logic [WC_W-1:0]  words;
  logic             ar_hold, aw_hold;

  wire on_last  = (on_len == '0) || (cnt == on_len - 1'b1);
  wire off_last = (off_len == '0) || (cnt == off_len - 1'b1);
  wire restart  = on_phase ? (on_last && off_len == '0) : off_last;

  wire window   = on_phase && (on_len != '0);
  wire in_cap   = (word_cap == '0) || (words < {1'b0, word_cap});
  wire allow    = window && in_cap;

  wire [1:0]      beats = {1'b0, rvalid_i & rready_i} + {1'b0, wvalid_i & wready_i};
  wire [WC_W:0]   wsum  = {1'b0, words} + {{(WC_W-1){1'b0}}, beats};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_phase <= 1'b1;
      cnt      <= '0;
    end else if (on_phase) begin
      if (on_last) begin
        cnt      <= '0;
        on_phase <= (off_len == '0);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (off_last) begin
        cnt      <= '0;
        on_phase <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       words <= '0;
    else if (restart) words <= '0;
    else if (wsum[WC_W]) words <= '1;
    else              words <= wsum[WC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ar_hold <= 1'b0;
      aw_hold <= 1'b0;
    end else begin
      ar_hold <= arvalid_o && !arready_i;
      aw_hold <= awvalid_o && !awready_i;
    end
  end

  assign ar_en     = allow || ar_hold;
  assign aw_en     = allow || aw_hold;
  assign arvalid_o = arvalid_i && ar_en;
  assign arready_o = arready_i && ar_en;
  assign awvalid_o = awvalid_i && aw_en;
  assign awready_o = awready_i && aw_en;
endmodule

module addr_pulse_gate_chk #(
  parameter int LEN_W = 16,
  parameter int CAP_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LEN_W-1:0] on_len,
  input logic [CAP_W-1:0] word_cap,
  input logic             on_phase,
  input logic [LEN_W-1:0] cnt,
  input logic [CAP_W:0]   words,
  input logic             ar_hold,
  input logic             aw_hold,
  input logic             arvalid_i,
  input logic             arvalid_o,
  input logic             arready_i,
  input logic             arready_o,
  input logic             awvalid_i,
  input logic             awvalid_o,
  input logic             awready_i,
  input logic             awready_o
);
  // R10
  ar_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid_o && !arready_i) |=> (arvalid_o || !arvalid_i));
  // R10
  aw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid_o && !awready_i) |=> (awvalid_o || !awvalid_i));
  // R3
  off_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_phase && !ar_hold && !aw_hold) |-> !(arready_o || awready_o));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_phase && on_len != '0) |-> (cnt < on_len));
  // R7
  cap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_cap != '0 && words >= {1'b0, word_cap} && !ar_hold) |-> !arvalid_o);
  // R8
  new_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_phase) |-> (words == '0));
endmodule

bind addr_pulse_gate addr_pulse_gate_chk #(.LEN_W(LEN_W), .CAP_W(CAP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .on_len(on_len), .word_cap(word_cap),
  .on_phase(on_phase), .cnt(cnt), .words(words), .ar_hold(ar_hold), .aw_hold(aw_hold),
  .arvalid_i(arvalid_i), .arvalid_o(arvalid_o), .arready_i(arready_i), .arready_o(arready_o),
  .awvalid_i(awvalid_i), .awvalid_o(awvalid_o), .awready_i(awready_i), .awready_o(awready_o)
);

// File: tb/addr_pulse_gate_tb.sv
`timescale 1ns/1ps
module addr_pulse_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] on_len = 16'd5, off_len = 16'd3, word_cap = 16'd0;
  logic arvalid_i = 1'b1, arready_i = 1'b1, awvalid_i = 1'b1, awready_i = 1'b1;
  logic rvalid_i = 1'b0, rready_i = 1'b0, wvalid_i = 1'b0, wready_i = 1'b0;
  logic arready_o, arvalid_o, awready_o, awvalid_o, ar_en, aw_en;

  int errors = 0, checks = 0;
  int idx, words;

  always #2.5 clk = ~clk;

  addr_pulse_gate dut_i (
    .clk(clk), .rst_n(rst_n), .on_len(on_len), .off_len(off_len), .word_cap(word_cap),
    .arvalid_i(arvalid_i), .arready_o(arready_o), .arvalid_o(arvalid_o), .arready_i(arready_i),
    .awvalid_i(awvalid_i), .awready_o(awready_o), .awvalid_o(awvalid_o), .awready_i(awready_i),
    .rvalid_i(rvalid_i), .rready_i(rready_i), .wvalid_i(wvalid_i), .wready_i(wready_i),
    .ar_en(ar_en), .aw_en(aw_en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, idx);
    end
  endtask

  task automatic do_reset(input int on, input int off, input int cap);
    @(negedge clk);
    rst_n = 1'b0;
    on_len = on[15:0]; off_len = off[15:0]; word_cap = cap[15:0];
    arvalid_i = 1'b1; arready_i = 1'b1; awvalid_i = 1'b1; awready_i = 1'b1;
    rvalid_i = 1'b0; rready_i = 1'b0; wvalid_i = 1'b0; wready_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idx = 0; words = 0;
  endtask

  function automatic bit exp_open();
    int p = on_len + off_len;
    bit win = (p != 0) && ((idx % p) < on_len);
    return win && (word_cap == 0 || words < word_cap);
  endfunction

  task automatic step(input bit rb, input bit wb);
    int p = on_len + off_len;
    rvalid_i = rb; rready_i = rb; wvalid_i = wb; wready_i = wb;
    @(posedge clk);
    @(negedge clk);
    if (p != 0 && (idx % p) == p - 1) words = 0;
    else words = words + rb + wb;
    idx++;
    rvalid_i = 1'b0; rready_i = 1'b0; wvalid_i = 1'b0; wready_i = 1'b0;
  endtask

  task automatic cmp_all(input string req);
    bit e = exp_open();
    chk(ar_en == e, req, ar_en, e);
    chk(aw_en == e, {req, " R11"}, aw_en, e);
    chk(arvalid_o == e && awvalid_o == e, {req, " R3"}, arvalid_o, e);
    chk(arready_o == e && awready_o == e, {req, " R3"}, arready_o, e);
  endtask

  task automatic t_reset();
    do_reset(5, 3, 0);
    chk(ar_en == 1'b1 && aw_en == 1'b1, "R1", ar_en, 1);
  endtask

  task automatic t_window();
    do_reset(5, 3, 0);
    for (int i = 0; i < 24; i++) begin cmp_all("R2"); step(0, 0); end
  endtask

  task automatic t_no_off();
    do_reset(6, 0, 0);
    for (int i = 0; i < 15; i++) begin cmp_all("R4"); step(0, 0); end
  endtask

  task automatic t_no_on();
    do_reset(0, 4, 0);
    for (int i = 0; i < 12; i++) begin
      chk(ar_en == 1'b0 && aw_en == 1'b0, "R5", ar_en, 0);
      step(0, 0);
    end
  endtask

  task automatic t_cap();
    do_reset(12, 3, 3);
    for (int i = 0; i < 30; i++) begin
      cmp_all("R7");
      step((idx % 15) < 4, 1'b0);
    end
    do_reset(12, 3, 5);
    for (int i = 0; i < 30; i++) begin
      cmp_all("R6 W");
      step(1'b0, (idx % 15) < 6);
    end
  endtask

  task automatic t_dual();
    do_reset(10, 2, 4);
    for (int i = 0; i < 24; i++) begin
      cmp_all("R6 dual");
      step((idx % 12) < 2, (idx % 12) < 2);
    end
  endtask

  task automatic t_boundary();
    do_reset(6, 2, 2);
    for (int i = 0; i < 16; i++) begin
      cmp_all("R8");
      step((idx % 8) == 7 || (idx % 8) == 0, 1'b0);
    end
  endtask

  task automatic t_unlimited();
    do_reset(8, 2, 0);
    for (int i = 0; i < 20; i++) begin cmp_all("R9"); step(1, 1); end
  endtask

  task automatic t_hold();
    do_reset(4, 4, 0);
    arready_i = 1'b0; awvalid_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk(arvalid_o == 1'b1, "R10 held valid", arvalid_o, 1);
      step(0, 0);
    end
    chk(awvalid_o == 1'b0 && awready_o == 1'b0, "R11 aw closed", aw_en, 0);
    arready_i = 1'b1;
    #0.5;
    chk(arvalid_o == 1'b1 && arready_o == 1'b1, "R10 accept", arready_o, 1);
    step(0, 0);
    chk(arvalid_o == 1'b0 && ar_en == 1'b0, "R10 released", arvalid_o, 0);
  endtask

  initial begin
    t_reset();
    t_window();
    t_no_off();
    t_no_on();
    t_cap();
    t_dual();
    t_boundary();
    t_unlimited();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule